// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the array word address for every cycle of a four-word burst in front of a pipelined synchronous memory. A load cycle with the chip selected takes in an external start address. Each later advance cycle steps only the two low address bits to the next burst position. The upper bits stay as loaded.

A static order input picks the stepping rule. In sequential order the low bits count upward from the start offset and wrap. In XOR order they are the start offset combined with a step counter. A load cycle with the chip not selected stops the running burst. While clock enable is inactive, all state is frozen. The address output and the burst-active flag are both registered.

Top module: `burst_addr_gen`

## Requirements
- R1: During and right after synchronous reset, `cur_addr` is 0 and `burst_act` is 0.
- R2: A cycle with `clk_en`=1, `load_n`=0 and `sel_ok`=1 makes `cur_addr` equal to `ext_addr` and sets `burst_act` to 1 after that clock edge.
- R3: An advance cycle (`clk_en`=1, `load_n`=1) ignores `ext_addr`. It leaves every address bit above the two low bits unchanged.
- R4: With `order_il`=0, advance k (k = 1, 2, …) after a load with start offset s gives low bits (s + k) mod 4.
- R5: With `order_il`=1, advance k after a load with start offset s gives low bits s XOR (k mod 4).
- R6: A cycle with `clk_en`=0 leaves `cur_addr` and `burst_act` unchanged, whatever the other inputs are.
- R7: A cycle with `clk_en`=1, `load_n`=0 and `sel_ok`=0 clears `burst_act` and leaves `cur_addr` unchanged.
- R8: An advance after the fourth word wraps to the first word of the same burst, and `burst_act` stays 1.
- R9: An advance while no burst is active returns `cur_addr` to the last loaded start address, and `burst_act` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable, active high; when low all state holds |
| load_n | input | 1 | 0 = load a new address, 1 = advance the burst |
| sel_ok | input | 1 | Chip-select decode result, 1 = selected |
| order_il | input | 1 | Static burst order: 1 = XOR order, 0 = sequential order |
| ext_addr | input | ADDR_W | External start address |
| cur_addr | output | ADDR_W | Registered word address for this cycle |
| burst_act | output | 1 | Registered flag, 1 while a burst is running |

## Verification
Both orders are swept over all four start offsets. Each start is paired with a random upper address and followed by six advances that carry random junk on `ext_addr`. This separates the two stepping rules, shows that a low-bit carry never reaches the upper bits, and exposes the wrap after the fourth word. Separate patterns cover the following:
- freezing the state with clock enable low while load or advance is presented;
- a deselected load that must stop the burst without moving the address;
- advances with no burst running, which must fall back to the loaded start.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STOP = 2'd2,
    OP_ADV  = 2'd3
  } bag_op_e;
endpackage

// File: rtl/bag_decode.sv
module bag_decode
  import bag_pkg::*;
(
  input  logic    clk_en,
  input  logic    load_n,
  input  logic    sel_ok,
  output bag_op_e op
);
  always_comb begin
    if (!clk_en)     op = OP_HOLD;
    else if (load_n) op = OP_ADV;
    else if (sel_ok) op = OP_LOAD;
    else             op = OP_STOP;
  end
endmodule

// File: rtl/bag_counter.sv
module bag_counter
  import bag_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  bag_op_e          op,
  output logic [OFS_W-1:0] step_nxt,
  output logic             act_q
);
  logic [OFS_W-1:0] step_q;
  logic             act_nxt;

  always_comb begin
    step_nxt = step_q;
    act_nxt  = act_q;
    case (op)
      OP_LOAD: begin
        step_nxt = '0;
        act_nxt  = 1'b1;
      end
      OP_STOP: act_nxt = 1'b0;
      OP_ADV:  step_nxt = act_q ? step_q + 1'b1 : '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      act_q  <= 1'b0;
    end else begin
      step_q <= step_nxt;
      act_q  <= act_nxt;
    end
  end
endmodule

// File: rtl/bag_order.sv
module bag_order #(
  parameter int OFS_W = 2
) (
  input  logic             il,
  input  logic [OFS_W-1:0] start,
  input  logic [OFS_W-1:0] step,
  output logic [OFS_W-1:0] low
);
  logic [OFS_W-1:0] seq_low;
  logic [OFS_W-1:0] xor_low;

  assign seq_low = start + step;
  assign xor_low = start ^ step;
  assign low     = il ? xor_low : seq_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              load_n,
  input  logic              sel_ok,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_act
);
  localparam int HI_W = ADDR_W - OFS_W;

  bag_op_e          op;
  logic [OFS_W-1:0] step_nxt;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_src;
  logic [OFS_W-1:0] low_nxt;

  bag_decode u_dec (
    .clk_en (clk_en),
    .load_n (load_n),
    .sel_ok (sel_ok),
    .op     (op)
  );

  bag_counter #(.OFS_W(OFS_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .step_nxt (step_nxt),
    .act_q    (burst_act)
  );

  assign base_src = (op == OP_LOAD) ? ext_addr : base_q;

  bag_order #(.OFS_W(OFS_W)) u_ord (
    .il    (order_il),
    .start (base_src[OFS_W-1:0]),
    .step  (step_nxt),
    .low   (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cur_addr <= '0;
    end else begin
      if (op == OP_LOAD) base_q <= ext_addr;
      if (op == OP_LOAD || op == OP_ADV)
        cur_addr <= {base_src[ADDR_W-1 -: HI_W], low_nxt};
    end
  end
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
  parameter int ADDR_W = 17,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              load_n,
  input logic              sel_ok,
  input logic              order_il,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              burst_act
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    past_ok && $past(rst) |-> (cur_addr == '0) && !burst_act); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(clk_en && !load_n && sel_ok)
    |-> (cur_addr == $past(ext_addr)) && burst_act); // R2

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(clk_en && load_n)
    |-> cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W])); // R3

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(clk_en && load_n && burst_act && !order_il)
    |-> cur_addr[OFS_W-1:0] == $past(cur_addr[OFS_W-1:0]) + 1'b1); // R4

  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && !$past(clk_en)
    |-> $stable(cur_addr) && $stable(burst_act)); // R6

  AST_STOP_BURST: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(clk_en && !load_n && !sel_ok)
    |-> !burst_act && $stable(cur_addr)); // R7
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en    (clk_en),
  .load_n    (load_n),
  .sel_ok    (sel_ok),
  .order_il  (order_il),
  .ext_addr  (ext_addr),
  .cur_addr  (cur_addr),
  .burst_act (burst_act)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 17;
  localparam int HW = AW - 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic          load_n = 1'b1;
  logic          sel_ok = 1'b0;
  logic          order_il = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          burst_act;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .OFS_W(2)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .load_n(load_n), .sel_ok(sel_ok),
    .order_il(order_il), .ext_addr(ext_addr), .cur_addr(cur_addr),
    .burst_act(burst_act)
  );

  task automatic step(input logic ce, input logic ld_n, input logic sel,
                      input logic [AW-1:0] a);
    clk_en = ce; load_n = ld_n; sel_ok = sel; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] got,
                     input logic [AW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [AW-1:0] held;
    logic [HW-1:0] hi;
    logic [1:0]    lo;

    rst = 1'b1;
    step(1, 0, 1, 17'h1abcd);
    step(1, 0, 1, 17'h0f00f);
    chk("R1 addr", cur_addr, '0);
    chk("R1 act", {{(AW-1){1'b0}}, burst_act}, '0);
    rst = 1'b0;

    // Sweep: both orders, every start offset, six advances each (R2 R3 R4 R5 R8)
    for (int m = 0; m < 2; m++) begin
      order_il = m[0];
      for (int s = 0; s < 4; s++) begin
        hi = HW'($urandom);
        a  = {hi, s[1:0]};
        step(1, 0, 1, a);
        chk("R2 load addr", cur_addr, a);
        chk("R2 load act", {{(AW-1){1'b0}}, burst_act}, {{(AW-1){1'b0}}, 1'b1});
        for (int k = 1; k <= 6; k++) begin
          step(1, 1, $urandom_range(0, 1), AW'($urandom));
          if (m == 1) lo = 2'(s ^ (k % 4));
          else        lo = 2'((s + k) % 4);
          chk(m == 1 ? "R5 R3 R8 xor step" : "R4 R3 R8 seq step", cur_addr, {hi, lo});
          chk("R8 act kept", {{(AW-1){1'b0}}, burst_act}, {{(AW-1){1'b0}}, 1'b1});
        end
      end
    end

    // R6: clock enable low freezes state
    order_il = 1'b0;
    a = 17'h12346;
    step(1, 0, 1, a);
    step(1, 1, 1, 17'h0);
    held = cur_addr;
    chk("R4 pre-freeze", held, 17'h12347);
    step(0, 0, 1, 17'h00111);
    chk("R6 load frozen", cur_addr, held);
    step(0, 1, 1, 17'h00222);
    chk("R6 adv frozen", cur_addr, held);
    step(0, 0, 0, 17'h00333);
    chk("R6 stop frozen act", {{(AW-1){1'b0}}, burst_act}, {{(AW-1){1'b0}}, 1'b1});
    step(1, 1, 1, 17'h0);
    chk("R6 resumes", cur_addr, 17'h12344);

    // R7: deselected load stops burst, address holds
    step(1, 0, 0, 17'h1ffff);
    chk("R7 addr held", cur_addr, 17'h12344);
    chk("R7 act cleared", {{(AW-1){1'b0}}, burst_act}, '0);

    // R9: advance with no burst returns to loaded start
    step(1, 1, 1, 17'h0aaaa);
    chk("R9 back to start", cur_addr, a);
    chk("R9 act stays low", {{(AW-1){1'b0}}, burst_act}, '0);
    step(1, 1, 0, 17'h05555);
    chk("R9 repeat start", cur_addr, a);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule